// File: doc/BRIEF.md
# Sixteen-Bit Compare/PWM Timer

A 16-bit counter advances once per timer event and drives three compare channels. An event comes from one of two places: a single-cycle prescaled tick supplied from outside, or an edge on an external pin. Software chooses the source and, for the pin, whether the rising or the falling edge counts. The counter runs in one of two modes. In sawtooth mode it counts up and wraps. In triangle mode it counts up and then down. The turning point at the top is a fixed value or is taken from a register.

Each channel has a buffer register that software writes and an active register that the comparator uses. The active register takes the buffer value only at the period boundary, so an update never cuts a pulse short. Each channel drives either a PWM level or a toggling output. A period boundary sets an overflow flag, and a compare hit on a channel sets that channel's flag. The flags are masked one by one and combined into a single interrupt line.

Registers are reached over a plain write/read bus. A read returns its data one cycle after the request.

Top module: `ptmr16`

## Requirements
- R1: After reset the counter, control, compare, capture, flag and mask registers are all zero, the outputs `wave_out` and `irq` are low, and register reads return zero.
- R2: The event source is control bits [1:0] at address 0: 0 = none, 1 = tick, 2 = pin rising edge, 3 = pin falling edge. With no event the counter holds its value. A bus write to address 1 loads the counter directly, and a read of address 1 returns it.
- R3: Control bit 2 = 0 selects sawtooth mode. Each event adds one. An event at which the count equals TOP sets the count to zero instead. Control bits [4:3] select TOP: 0 = 0xFFFF, 1 = 0x00FF.
- R4: Control bit 2 = 1 selects triangle mode. Counting up, an event at a count not below TOP (and not zero) reverses the direction and subtracts one. Counting down, an event at zero reverses the direction and adds one.
- R5: A TOP select of 2 uses the active channel-A compare value. A TOP select of 3 uses the capture register at address 5.
- R6: The compare buffers are at addresses 2, 3 and 4 (channels A, B, C) and read back the buffer value. A buffer reaches the active register only at the period boundary: the wrap at TOP in sawtooth mode, or the event at zero while counting down in triangle mode.
- R7: In PWM mode (control bit 5+i = 0), `wave_out[i]` is high exactly while the count is below channel i's active compare value.
- R8: In toggle mode (control bit 5+i = 1), `wave_out[i]` inverts on every event at which the count equals channel i's active compare value.
- R9: The flag register at address 6 has bit 0 for the period boundary and bit 1+i for a compare hit on channel i. Writing a 1 to a flag bit clears that bit; a set in the same cycle wins.
- R10: `irq` is high when any flag bit is set whose bit in the mask register (address 7) is also set.
- R11: The pin passes through two synchronizer stages before edge detection. A pin change made before clock edge 1 changes the count at clock edge 3.
- R12: Writing control with bit 8 set clears the counter to zero and the direction to up. The bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read request |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| tick_in | input | 1 | Prescaled internal event, one cycle per event |
| ext_pin | input | 1 | Asynchronous external event pin |
| wave_out | output | 3 | Channel waveform outputs |
| irq | output | 1 | Masked interrupt request |

## Verification
The counter, the flags and the active compare values change at the clock edge that samples an event or a bus write. `wave_out` and `irq` follow that state combinationally. The bench therefore drives at falling edges and checks those outputs at the next falling edge. A read result is due one edge after the request, and it carries the count from before any update at that same edge. The scoreboard queues the expected word when the request is issued and compares it at the following falling edge. A pin change reaches the count only at the third rising edge. The bench confirms that timing with two back-to-back reads that must return the old count and then the new one.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    SRC_OFF      = 2'd0,
    SRC_TICK     = 2'd1,
    SRC_EXT_RISE = 2'd2,
    SRC_EXT_FALL = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    TOP_ALL  = 2'd0,
    TOP_HALF = 2'd1,
    TOP_CMPA = 2'd2,
    TOP_CAPT = 2'd3
  } top_e;

  typedef struct packed {
    logic [NCH-1:0] tgl;
    top_e           top;
    logic           updn;
    src_e           src;
  } ctrl_t;

  localparam int CTRL_CLR_BIT = 8;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_COUNT = 3'd1;
  localparam logic [2:0] RA_CMPA  = 3'd2;
  localparam logic [2:0] RA_CMPB  = 3'd3;
  localparam logic [2:0] RA_CMPC  = 3'd4;
  localparam logic [2:0] RA_CAPT  = 3'd5;
  localparam logic [2:0] RA_FLAGS = 3'd6;
  localparam logic [2:0] RA_MASK  = 3'd7;
endpackage

// File: rtl/ptmr_evsel.sv
module ptmr_evsel
  import ptmr_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic tick,
  input  logic ext_pin,
  output logic ev
);
  logic [SYNC:0] sh_q;
  logic          pin_rise;
  logic          pin_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], ext_pin};
  end

  assign pin_rise = sh_q[SYNC-1] & ~sh_q[SYNC];
  assign pin_fall = ~sh_q[SYNC-1] & sh_q[SYNC];

  always_comb begin
    case (src)
      SRC_OFF:      ev = 1'b0;
      SRC_TICK:     ev = tick;
      SRC_EXT_RISE: ev = pin_rise;
      default:      ev = pin_fall;
    endcase
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         updn,
  input  top_e         top_sel,
  input  logic [W-1:0] cmpa,
  input  logic [W-1:0] capt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top_val,
  output logic         dir_down,
  output logic         cycle_ev
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] HALF = {{(W-W/2){1'b0}}, {(W/2){1'b1}}};

  function automatic logic [W-1:0] pick_top(top_e sel, logic [W-1:0] a, logic [W-1:0] c);
    case (sel)
      TOP_ALL:  return '1;
      TOP_HALF: return HALF;
      TOP_CMPA: return a;
      default:  return c;
    endcase
  endfunction

  logic [W-1:0] nxt_cnt;
  logic         nxt_dir;
  logic         bound;

  assign top_val = pick_top(top_sel, cmpa, capt);

  always_comb begin
    nxt_cnt = cnt;
    nxt_dir = dir_down;
    bound   = 1'b0;
    if (ev) begin
      if (!updn) begin
        nxt_dir = 1'b0;
        if (cnt == top_val) begin
          nxt_cnt = '0;
          bound   = 1'b1;
        end else begin
          nxt_cnt = cnt + ONE;
        end
      end else if (!dir_down) begin
        if (cnt >= top_val && cnt != '0) begin
          nxt_dir = 1'b1;
          nxt_cnt = cnt - ONE;
        end else begin
          nxt_cnt = cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          nxt_dir = 1'b0;
          nxt_cnt = ONE;
          bound   = 1'b1;
        end else begin
          nxt_cnt = cnt - ONE;
        end
      end
    end
  end

  assign cycle_ev = bound & ~wr_en & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (clr) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (wr_en) begin
      cnt      <= wr_data;
    end else begin
      cnt      <= nxt_cnt;
      dir_down <= nxt_dir;
    end
  end
endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_buf,
  input  logic [W-1:0] wdata,
  input  logic         load,
  input  logic         ev,
  input  logic [W-1:0] cnt,
  input  logic         tgl_mode,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         hit,
  output logic         wave
);
  function automatic logic pwm_level(logic [W-1:0] c, logic [W-1:0] cmp);
    return c < cmp;
  endfunction

  logic tgl_q;

  assign hit  = ev & (cnt == act_q);
  assign wave = tgl_mode ? tgl_q : pwm_level(cnt, act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      if (wr_buf) buf_q <= wdata;
      if (load)   act_q <= buf_q;
      if (hit)    tgl_q <= ~tgl_q;
    end
  end
endmodule

// File: rtl/ptmr16.sv
module ptmr16
  import ptmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tick_in,
  input  logic             ext_pin,
  output logic [NCH-1:0]   wave_out,
  output logic             irq
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLG_W  = NCH + 1;

  ctrl_t                       ctrl_q;
  logic [CNT_W-1:0]            capt_q;
  logic [FLG_W-1:0]            flag_q;
  logic [FLG_W-1:0]            mask_q;
  logic [CNT_W-1:0]            rd_mux;

  logic                        ev;
  logic                        updn_mode;
  logic [CNT_W-1:0]            cnt;
  logic [CNT_W-1:0]            top_val;
  logic                        dir_down;
  logic                        cycle_ev;
  logic                        wr_cnt;
  logic                        wr_ctrl;
  logic                        wr_flags;
  logic                        ctl_clr;
  logic [FLG_W-1:0]            flag_clr;
  logic [NCH-1:0]              hit;
  logic [NCH-1:0]              wave;
  logic [NCH-1:0][CNT_W-1:0]   cmp_buf;
  logic [NCH-1:0][CNT_W-1:0]   cmp_act;

  assign wr_ctrl   = bus_we && (bus_addr == RA_CTRL);
  assign wr_cnt    = bus_we && (bus_addr == RA_COUNT);
  assign wr_flags  = bus_we && (bus_addr == RA_FLAGS);
  assign ctl_clr   = wr_ctrl && bus_wdata[CTRL_CLR_BIT];
  assign flag_clr  = wr_flags ? bus_wdata[FLG_W-1:0] : '0;
  assign updn_mode = ctrl_q.updn;

  ptmr_evsel #(.SYNC(SYNC_STAGES)) u_evsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (ctrl_q.src),
    .tick    (tick_in),
    .ext_pin (ext_pin),
    .ev      (ev)
  );

  ptmr_core #(.W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .updn     (ctrl_q.updn),
    .top_sel  (ctrl_q.top),
    .cmpa     (cmp_act[0]),
    .capt     (capt_q),
    .wr_en    (wr_cnt),
    .wr_data  (bus_wdata),
    .clr      (ctl_clr),
    .cnt      (cnt),
    .top_val  (top_val),
    .dir_down (dir_down),
    .cycle_ev (cycle_ev)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam logic [2:0] CH_ADDR = RA_CMPA + 3'(gi);
    ptmr_chan #(.W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_buf   (bus_we && (bus_addr == CH_ADDR)),
      .wdata    (bus_wdata),
      .load     (cycle_ev),
      .ev       (ev),
      .cnt      (cnt),
      .tgl_mode (ctrl_q.tgl[gi]),
      .buf_q    (cmp_buf[gi]),
      .act_q    (cmp_act[gi]),
      .hit      (hit[gi]),
      .wave     (wave[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      capt_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl)                          ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_we && bus_addr == RA_CAPT)    capt_q <= bus_wdata;
      if (bus_we && bus_addr == RA_MASK)    mask_q <= bus_wdata[FLG_W-1:0];
      flag_q <= (flag_q & ~flag_clr) | {hit, cycle_ev};
    end
  end

  always_comb begin
    case (bus_addr)
      RA_CTRL:  rd_mux = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      RA_COUNT: rd_mux = cnt;
      RA_CMPA:  rd_mux = cmp_buf[0];
      RA_CMPB:  rd_mux = cmp_buf[1];
      RA_CMPC:  rd_mux = cmp_buf[2];
      RA_CAPT:  rd_mux = capt_q;
      RA_FLAGS: rd_mux = {{(CNT_W-FLG_W){1'b0}}, flag_q};
      default:  rd_mux = {{(CNT_W-FLG_W){1'b0}}, mask_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign wave_out = wave;
  assign irq      = |(flag_q & mask_q);
endmodule

// File: rtl/ptmr16_chk.sv
module ptmr16_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev,
  input logic             wr_cnt,
  input logic             clr,
  input logic             updn,
  input logic             dir_down,
  input logic             cycle_ev,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     top_val,
  input logic [NCH*W-1:0] cmp_buf,
  input logic [NCH*W-1:0] cmp_act,
  input logic [NCH:0]     flags
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !wr_cnt && !clr) |=> $stable(cnt)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !updn && cnt != top_val && !wr_cnt && !clr) |=> (cnt == W'($past(cnt) + 1'b1))); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_ev && !updn) |=> (cnt == '0)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && updn && dir_down && cnt != '0 && !wr_cnt && !clr) |=> (cnt == W'($past(cnt) - 1'b1))); // R4

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_ev |=> $stable(cmp_act)); // R6

  AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_ev |=> (cmp_act == $past(cmp_buf))); // R6

  AST_BOUND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_ev |=> flags[0]); // R9
endmodule

bind ptmr16 ptmr16_chk #(.W(CNT_W), .NCH(ptmr_pkg::NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev       (ev),
  .wr_cnt   (wr_cnt),
  .clr      (ctl_clr),
  .updn     (updn_mode),
  .dir_down (dir_down),
  .cycle_ev (cycle_ev),
  .cnt      (cnt),
  .top_val  (top_val),
  .cmp_buf  (cmp_buf),
  .cmp_act  (cmp_act),
  .flags    (flag_q)
);

// File: tb/test_ptmr16.sv
module test_ptmr16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         tick = 1'b0;
  logic         ext_pin = 1'b0;
  logic [2:0]   wave;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_issued = 1'b0;

  always #4 clk = ~clk;

  ptmr16 i_ptmr16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_in   (tick),
    .ext_pin   (ext_pin),
    .wave_out  (wave),
    .irq       (irq)
  );

  // monitor: read data is due one edge after the request
  always @(posedge clk) rd_issued <= bus_re;

  always @(negedge clk) begin : mon
    logic [W-1:0] e;
    string        t;
    if (rd_issued) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string t);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic a, input logic e, input string t);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, a, e);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(wave[0], 1'b0, "R1 wave A");
    chk(wave[1], 1'b0, "R1 wave B");
    chk(irq, 1'b0, "R1 irq");
    rd(3'd0, 16'h0000, "R1 ctrl");
    rd(3'd1, 16'h0000, "R1 count");
    rd(3'd6, 16'h0000, "R1 flags");
    rd(3'd2, 16'h0000, "R1 cmpA");

    // R2 no source holds, direct load
    ticks(5);
    rd(3'd1, 16'h0000, "R2 hold with no source");
    wr(3'd1, 16'h0010);
    ticks(3);
    rd(3'd1, 16'h0010, "R2 loaded value held");

    // R3 sawtooth with half-range top
    wr(3'd0, 16'h0009);
    wr(3'd1, 16'h00FD);
    wr(3'd6, 16'h000F);
    ticks(2);
    rd(3'd1, 16'h00FF, "R3 count up");
    ticks(1);
    rd(3'd1, 16'h0000, "R3 wrap at top");
    rd(3'd6, 16'h0001, "R9 boundary flag");

    // R10 masking, R9 clear
    chk(irq, 1'b0, "R10 masked off");
    wr(3'd7, 16'h0001);
    chk(irq, 1'b1, "R10 unmasked");
    wr(3'd7, 16'h0002);
    chk(irq, 1'b0, "R10 other mask bit");
    wr(3'd7, 16'h0001);
    wr(3'd6, 16'h0001);
    chk(irq, 1'b0, "R10 after clear");
    rd(3'd6, 16'h0000, "R9 write one clears");

    // R5/R6/R7 top from channel A, buffered compare
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'h0009);
    rd(3'd2, 16'h0009, "R6 buffer readback");
    ticks(1);
    rd(3'd1, 16'h0000, "R5 wrap at old active A");
    ticks(5);
    wr(3'd3, 16'h0003);
    chk(wave[1], 1'b0, "R6 buffer not yet active");
    ticks(5);
    rd(3'd1, 16'h0000, "R5 top from channel A");
    chk(wave[1], 1'b1, "R7 count below compare");
    wr(3'd6, 16'h000F);
    ticks(3);
    chk(wave[1], 1'b0, "R7 count equals compare");
    rd(3'd6, 16'h0008, "R9 channel C hit only");
    ticks(1);
    rd(3'd6, 16'h000C, "R9 channel B hit");
    rd(3'd1, 16'h0004, "R3 count after hit");

    // R8 toggle on channel C
    wr(3'd0, 16'h0091);
    wr(3'd4, 16'h0002);
    w0 = wave[2];
    ticks(8);
    chk(wave[2], w0, "R8 no toggle before match");
    ticks(1);
    chk(wave[2], ~w0, "R8 toggle on match");
    ticks(9);
    chk(wave[2], ~w0, "R8 held between matches");
    ticks(1);
    chk(wave[2], w0, "R8 second toggle");

    // R4 triangle mode, R6 load at bottom
    wr(3'd0, 16'h0015);
    wr(3'd1, 16'h0008);
    ticks(2);
    rd(3'd1, 16'h0008, "R4 reverse at top");
    ticks(8);
    rd(3'd1, 16'h0000, "R4 count down to zero");
    wr(3'd6, 16'h000F);
    wr(3'd3, 16'h0005);
    ticks(1);
    rd(3'd1, 16'h0001, "R4 reverse at bottom");
    rd(3'd6, 16'h0001, "R9 boundary at bottom");
    ticks(3);
    chk(wave[1], 1'b1, "R6 loaded at bottom");

    // R5 top from capture register
    wr(3'd0, 16'h0019);
    wr(3'd5, 16'h0004);
    wr(3'd1, 16'h0000);
    ticks(4);
    rd(3'd1, 16'h0004, "R5 count to capture top");
    ticks(1);
    rd(3'd1, 16'h0000, "R5 wrap at capture top");
    rd(3'd5, 16'h0004, "R5 capture readback");

    // R3 full-range top
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'hFFFE);
    ticks(1);
    rd(3'd1, 16'hFFFF, "R3 reach all ones");
    wr(3'd6, 16'h000F);
    ticks(1);
    rd(3'd1, 16'h0000, "R3 wrap at all ones");
    rd(3'd6, 16'h0001, "R9 boundary at full top");

    // R12 clear bit
    wr(3'd1, 16'h1234);
    wr(3'd0, 16'h0101);
    rd(3'd1, 16'h0000, "R12 count cleared");
    rd(3'd0, 16'h0001, "R12 clear bit not stored");

    // R11 external pin, rising then falling
    wr(3'd0, 16'h0002);
    ext_pin = 1'b1;
    idle(2);
    rd(3'd1, 16'h0000, "R11 not yet counted");
    rd(3'd1, 16'h0001, "R11 counted at third edge");
    ext_pin = 1'b0;
    idle(5);
    rd(3'd1, 16'h0001, "R11 falling ignored");
    wr(3'd0, 16'h0003);
    ext_pin = 1'b1;
    idle(5);
    rd(3'd1, 16'h0001, "R11 rising ignored");
    ext_pin = 1'b0;
    idle(5);
    rd(3'd1, 16'h0002, "R11 falling counted");

    idle(3);
    finish_run();
  end
endmodule